// File: doc/BRIEF.md
# UART Receive FIFO Controller with Character Timeout

This block is the receive-side buffer control of a 16550-class serial port. A deserializer upstream hands it one received character per `rx_valid` pulse, or a line break per `rx_break` pulse. The host side reads data through `data_rd` and `rd_data` and reads line status through `lsr_rd`. FIFO-control writes arrive already decoded as `fcr_wr` with the enable, receive-reset and trigger-select fields. The block keeps the data-ready, overrun and break status bits. It also compares the fill level against the programmed trigger level and runs a character-timeout timer whose length is four frames of the programmed frame format, counted in `bit_tick` pulses.

Two state machines shape the block. The mode machine has the states MODE_HOLD (single holding register) and MODE_FIFO (16-deep queue). A FIFO-control write with the enable field set takes the transition HOLD→FIFO, and one with the field clear takes FIFO→HOLD. Either change of mode flushes the receive side. The timer machine has the states TMR_IDLE and TMR_RUN. The transition IDLE/RUN→RUN is a restart, taken when a character arrives or when a read leaves data behind. RUN→IDLE is either an expiry, taken on the last bit tick of the window, or a cancel, taken on a receive flush or in hold mode.

Top module: `uart_rx_fifo_ctrl`

## Requirements
- R1: After reset, data-ready, overrun, break and timeout-pending are 0, the block is in hold mode, the fill count is 0, `rd_data` is 0 and `trig_hit` is 0.
- R2: In FIFO mode, bytes are read back in arrival order, data-ready equals "fill count is non-zero", and a read of an empty FIFO presents 0 on `rd_data`.
- R3: In FIFO mode, a byte that arrives while 16 bytes are stored is discarded, the stored bytes are unchanged, and overrun is set.
- R4: `fcr_trig` selects the trigger level (0→1, 1→4, 2→8, 3→14 bytes), and `trig_hit` is high in FIFO mode exactly when the fill count is at or above that level.
- R5: Frame length is 1 start bit, plus `lcr_fmt[1:0]`+5 data bits, plus 1 parity bit if `lcr_fmt[3]` is set, plus 2 stop bits if `lcr_fmt[2]` is set and 1 stop bit otherwise. Timeout-pending rises on the 4×frame-length-th `bit_tick` after the last restart, provided the FIFO holds data.
- R6: A data read clears timeout-pending. A read that leaves the FIFO non-empty restarts the timeout window.
- R7: A break event stores a zero byte and sets both break and data-ready.
- R8: A FIFO-control write with `fcr_rx_clr` set, or with `fcr_fifo_en` different from the current mode, empties the FIFO and clears data-ready, break, timeout-pending and the timer. Overrun is kept, and a byte arriving in the same cycle is dropped.
- R9: In hold mode the newest byte replaces the held one, and it sets overrun if data-ready was already set. A read clears data-ready, and the fill count stays 0.
- R10: A line-status read clears break and overrun and leaves data-ready as it is. A new overrun or break in the same cycle wins over the clear.
- R11: Break and data-ready are cleared by the data read that empties the FIFO, and not by a read that leaves data behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per serial bit period |
| lcr_fmt | input | 4 | Frame format: [1:0] data-length code, [2] two stop bits, [3] parity present |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Line break detected strobe |
| data_rd | input | 1 | Host read of the receive data location |
| rd_data | output | 8 | Data presented for the host read |
| lsr_rd | input | 1 | Host read of line status |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_fifo_en | input | 1 | Written FIFO enable field |
| fcr_rx_clr | input | 1 | Written receive-reset field |
| fcr_trig | input | 2 | Written trigger-level select |
| lsr_dr | output | 1 | Data ready |
| lsr_oe | output | 1 | Overrun error |
| lsr_bi | output | 1 | Break indication |
| timeout_pend | output | 1 | Character timeout pending |
| trig_hit | output | 1 | Receive level reached |
| fifo_en | output | 1 | FIFO mode active |
| rx_count | output | 5 | Bytes held in the FIFO |

## Verification
Every status bit, the fill count and the mode change at the rising edge that samples the strobe. `rd_data` follows from the queue head with no added register, so it is valid in the cycle before a read takes effect. The bench drives inputs on the falling edge, lets one rising edge pass and samples on the next falling edge, and it samples `rd_data` before it pulses the read. For the timeout, expiry is due on exactly the 4×frame-th ticked edge after a restart. The bench therefore checks that pending is still low after one tick fewer and high after the final one, for two different frame formats.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_FIFO = 1'b1
    } rx_mode_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    // Bits per frame: start + data + optional parity + stop bits.
    function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
        logic [3:0] n;
        n = 4'd6 + {2'b00, fmt[1:0]};
        n = n + {3'b000, fmt[3]};
        n = n + (fmt[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

    // Trigger level in bytes for a 2-bit select code.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        unique case (sel)
            2'd0: lvl = 5'd1;
            2'd1: lvl = 5'd4;
            2'd2: lvl = 5'd8;
            2'd3: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uart_rxf_store.sv
module uart_rxf_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) slot[wr_ptr] <= din;
    end

    assign dout  = slot[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/uart_rxf_timer.sv
module uart_rxf_timer
    import uart_rxf_pkg::*;
#(
    parameter int CHARS   = 4,
    parameter int MAXBITS = 12,
    localparam int LW = $clog2(CHARS * MAXBITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       cancel,
    input  logic       tick,
    input  logic [3:0] frame_len,
    output logic       fire
);

    tmr_state_e    state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] limit;
    logic          last_tick;

    assign limit     = LW'(CHARS) * LW'(frame_len);
    assign last_tick = tick && (cnt_q == limit - LW'(1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cancel) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else if (restart) begin
            state_d = TMR_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    cnt_d = '0;
                end
                TMR_RUN: begin
                    if (last_tick) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + LW'(1);
                    end
                end
            endcase
        end
    end

    // Output.
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TMR_IDLE: fire = 1'b0;
            TMR_RUN:  fire = last_tick && !cancel && !restart;
        endcase
    end

endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CHARS   = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic [3:0]    lcr_fmt,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_break,
    input  logic          data_rd,
    output logic [7:0]    rd_data,
    input  logic          lsr_rd,
    input  logic          fcr_wr,
    input  logic          fcr_fifo_en,
    input  logic          fcr_rx_clr,
    input  logic [1:0]    fcr_trig,
    output logic          lsr_dr,
    output logic          lsr_oe,
    output logic          lsr_bi,
    output logic          timeout_pend,
    output logic          trig_hit,
    output logic          fifo_en,
    output logic [CW-1:0] rx_count
);

    rx_mode_e   mode_q, mode_d;
    logic       in_fifo;
    logic       en_flip, rx_flush, arrive;
    logic [7:0] arr_byte;
    logic       st_push, st_pop, st_drop, st_full, st_empty;
    logic [7:0] st_dout;
    logic [CW-1:0] st_count;
    logic       fifo_empties, hold_ovr, rd_clears;
    logic       tmr_restart, tmr_cancel, tmr_fire;
    logic       dr_q, oe_q, bi_q, pend_q;
    logic [7:0] hold_q;
    logic [1:0] trig_sel_q;

    assign in_fifo  = (mode_q == MODE_FIFO);
    assign en_flip  = fcr_wr && (fcr_fifo_en != in_fifo);
    assign rx_flush = fcr_wr && (fcr_rx_clr || en_flip);
    assign arrive   = (rx_valid || rx_break) && !rx_flush;
    assign arr_byte = rx_break ? 8'h00 : rx_data;

    assign st_pop   = in_fifo && data_rd && !st_empty && !rx_flush;
    assign st_push  = in_fifo && arrive && (!st_full || st_pop);
    assign st_drop  = in_fifo && arrive && st_full && !st_pop;
    assign fifo_empties = st_pop && (st_count == CW'(1)) && !st_push;
    assign hold_ovr = !in_fifo && arrive && dr_q && !data_rd;
    assign rd_clears = in_fifo ? fifo_empties : data_rd;

    assign tmr_restart = in_fifo && !rx_flush &&
                         (arrive || (data_rd && st_count > CW'(1)));
    assign tmr_cancel  = rx_flush || !in_fifo;

    uart_rxf_store #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (st_push),
        .pop   (st_pop),
        .din   (arr_byte),
        .dout  (st_dout),
        .count (st_count),
        .full  (st_full),
        .empty (st_empty)
    );

    uart_rxf_timer #(.CHARS(CHARS), .MAXBITS(12)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (tmr_restart),
        .cancel    (tmr_cancel),
        .tick      (bit_tick),
        .frame_len (frame_bits(lcr_fmt)),
        .fire      (tmr_fire)
    );

    // Mode state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_HOLD;
        else        mode_q <= mode_d;
    end

    // Mode next state.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_HOLD: if (fcr_wr && fcr_fifo_en)  mode_d = MODE_FIFO;
            MODE_FIFO: if (fcr_wr && !fcr_fifo_en) mode_d = MODE_HOLD;
        endcase
    end

    // Line status, holding register, trigger select, timeout flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q       <= 1'b0;
            oe_q       <= 1'b0;
            bi_q       <= 1'b0;
            pend_q     <= 1'b0;
            hold_q     <= 8'h00;
            trig_sel_q <= 2'd0;
        end else begin
            if (fcr_wr) trig_sel_q <= fcr_trig;
            if (!in_fifo && arrive) hold_q <= arr_byte;

            if (rx_flush)       dr_q <= 1'b0;
            else if (arrive)    dr_q <= 1'b1;
            else if (rd_clears) dr_q <= 1'b0;

            if (rx_flush)                  bi_q <= 1'b0;
            else if (rx_break)             bi_q <= 1'b1;
            else if (lsr_rd || rd_clears)  bi_q <= 1'b0;

            if (st_drop || hold_ovr) oe_q <= 1'b1;
            else if (lsr_rd)         oe_q <= 1'b0;

            if (rx_flush || data_rd || !in_fifo)   pend_q <= 1'b0;
            else if (tmr_fire && !st_empty)        pend_q <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        unique case (mode_q)
            MODE_HOLD: begin
                rd_data  = hold_q;
                trig_hit = dr_q;
            end
            MODE_FIFO: begin
                rd_data  = st_empty ? 8'h00 : st_dout;
                trig_hit = (st_count >= CW'(trig_level(trig_sel_q)));
            end
        endcase
    end

    assign lsr_dr       = dr_q;
    assign lsr_oe       = oe_q;
    assign lsr_bi       = bi_q;
    assign timeout_pend = pend_q;
    assign fifo_en      = in_fifo;
    assign rx_count     = st_count;

endmodule

// File: rtl/uart_rxf_checker.sv
module uart_rxf_checker #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rx_break,
    input logic          data_rd,
    input logic          lsr_rd,
    input logic          fcr_wr,
    input logic          fcr_fifo_en,
    input logic          fcr_rx_clr,
    input logic          fifo_en,
    input logic [CW-1:0] rx_count,
    input logic          lsr_dr,
    input logic          lsr_oe,
    input logic          lsr_bi,
    input logic          timeout_pend
);

    a_r2_dr_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> (lsr_dr == (rx_count != '0)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_count == CW'(DEPTH) && rx_valid && !data_rd && !fcr_wr)
        |=> (rx_count == CW'(DEPTH) && lsr_oe));

    a_r5_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> (rx_count != '0));

    a_r6_read_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> !timeout_pend);

    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && (fcr_rx_clr || (fcr_fifo_en != fifo_en)))
        |=> (rx_count == '0 && !lsr_dr && !lsr_bi && !timeout_pend));

    a_r9_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_count == '0));

    a_r10_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_valid && !rx_break) |=> (!lsr_oe && !lsr_bi));

endmodule

bind uart_rx_fifo_ctrl uart_rxf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .data_rd      (data_rd),
    .lsr_rd       (lsr_rd),
    .fcr_wr       (fcr_wr),
    .fcr_fifo_en  (fcr_fifo_en),
    .fcr_rx_clr   (fcr_rx_clr),
    .fifo_en      (fifo_en),
    .rx_count     (rx_count),
    .lsr_dr       (lsr_dr),
    .lsr_oe       (lsr_oe),
    .lsr_bi       (lsr_bi),
    .timeout_pend (timeout_pend)
);

// File: tb/uart_rx_fifo_ctrl_bench.sv
module uart_rx_fifo_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [3:0] lcr_fmt = 4'b0011;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_break = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rd_data;
    logic       lsr_rd = 1'b0;
    logic       fcr_wr = 1'b0;
    logic       fcr_fifo_en = 1'b0;
    logic       fcr_rx_clr = 1'b0;
    logic [1:0] fcr_trig = 2'd0;
    logic       lsr_dr, lsr_oe, lsr_bi, timeout_pend, trig_hit, fifo_en;
    logic [4:0] rx_count;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uart_rx_fifo_ctrl u_uart_rx_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .lcr_fmt(lcr_fmt),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .data_rd(data_rd), .rd_data(rd_data), .lsr_rd(lsr_rd),
        .fcr_wr(fcr_wr), .fcr_fifo_en(fcr_fifo_en), .fcr_rx_clr(fcr_rx_clr),
        .fcr_trig(fcr_trig), .lsr_dr(lsr_dr), .lsr_oe(lsr_oe),
        .lsr_bi(lsr_bi), .timeout_pend(timeout_pend), .trig_hit(trig_hit),
        .fifo_en(fifo_en), .rx_count(rx_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; step(); rx_valid = 1'b0;
    endtask

    task automatic push_break();
        rx_break = 1'b1; step(); rx_break = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        b = rd_data; data_rd = 1'b1; step(); data_rd = 1'b0;
    endtask

    task automatic read_lsr();
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    endtask

    task automatic wr_fcr(input logic en, input logic clr, input logic [1:0] trig);
        fcr_wr = 1'b1; fcr_fifo_en = en; fcr_rx_clr = clr; fcr_trig = trig;
        step();
        fcr_wr = 1'b0; fcr_fifo_en = 1'b0; fcr_rx_clr = 1'b0;
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) step();
        bit_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dr", lsr_dr, 0);
        chk("R1 oe", lsr_oe, 0);
        chk("R1 bi", lsr_bi, 0);
        chk("R1 pend", timeout_pend, 0);
        chk("R1 fifo_en", fifo_en, 0);
        chk("R1 count", rx_count, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 trig_hit", trig_hit, 0);
    endtask

    task automatic t_hold();
        logic [7:0] b;
        push_byte(8'h11);
        chk("R9 dr set", lsr_dr, 1);
        chk("R9 data", rd_data, 8'h11);
        chk("R9 no overrun", lsr_oe, 0);
        push_byte(8'h22);
        chk("R9 overrun", lsr_oe, 1);
        chk("R9 newest kept", rd_data, 8'h22);
        chk("R9 count zero", rx_count, 0);
        read_byte(b);
        chk("R9 read value", b, 8'h22);
        chk("R9 dr cleared", lsr_dr, 0);
        chk("R10 oe survives data read", lsr_oe, 1);
        read_lsr();
        chk("R10 oe cleared", lsr_oe, 0);
    endtask

    task automatic t_fifo_order();
        logic [7:0] b;
        wr_fcr(1'b1, 1'b0, 2'd0);
        chk("R8 mode fifo", fifo_en, 1);
        push_byte(8'hA1); push_byte(8'hA2); push_byte(8'hA3);
        chk("R2 count", rx_count, 3);
        chk("R2 dr", lsr_dr, 1);
        for (int i = 0; i < 3; i++) begin
            read_byte(b);
            chk("R2 order", b, 8'hA1 + 8'(i));
        end
        chk("R11 dr after empty", lsr_dr, 0);
        chk("R2 empty read value", rd_data, 0);
    endtask

    task automatic t_trigger();
        int lvl;
        for (int s = 0; s < 4; s++) begin
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            wr_fcr(1'b1, 1'b1, 2'(s));
            for (int k = 0; k < lvl - 1; k++) push_byte(8'(k));
            chk("R4 below level", trig_hit, 0);
            push_byte(8'h5A);
            chk("R4 at level", trig_hit, 1);
        end
        wr_fcr(1'b1, 1'b1, 2'd0);
    endtask

    task automatic t_overrun();
        logic [7:0] b;
        for (int k = 0; k < 16; k++) push_byte(8'h40 + 8'(k));
        chk("R3 full count", rx_count, 16);
        chk("R3 no oe yet", lsr_oe, 0);
        push_byte(8'hEE);
        chk("R3 count kept", rx_count, 16);
        chk("R3 oe set", lsr_oe, 1);
        for (int k = 0; k < 16; k++) begin
            read_byte(b);
            chk("R3 contents", b, 8'h40 + 8'(k));
        end
        chk("R3 empty", rx_count, 0);
        read_lsr();
        chk("R10 oe cleared", lsr_oe, 0);
    endtask

    task automatic t_break();
        logic [7:0] b;
        push_break();
        chk("R7 count", rx_count, 1);
        chk("R7 dr", lsr_dr, 1);
        chk("R7 bi", lsr_bi, 1);
        chk("R7 zero byte", rd_data, 0);
        read_lsr();
        chk("R10 bi cleared", lsr_bi, 0);
        chk("R10 dr kept", lsr_dr, 1);
        push_break();
        read_byte(b);
        chk("R11 bi kept non-empty", lsr_bi, 1);
        read_byte(b);
        chk("R11 bi cleared on empty", lsr_bi, 0);
        chk("R11 dr cleared on empty", lsr_dr, 0);
    endtask

    task automatic t_timeout();
        logic [7:0] b;
        lcr_fmt = 4'b0011;
        push_byte(8'h01); push_byte(8'h02);
        ticks(39);
        chk("R5 not yet 8N1", timeout_pend, 0);
        ticks(1);
        chk("R5 expiry 8N1", timeout_pend, 1);
        read_byte(b);
        chk("R6 read clears", timeout_pend, 0);
        ticks(39);
        chk("R6 restarted window", timeout_pend, 0);
        ticks(1);
        chk("R6 expiry after read", timeout_pend, 1);
        wr_fcr(1'b1, 1'b1, 2'd0);
        chk("R8 pend cleared", timeout_pend, 0);
        chk("R8 count cleared", rx_count, 0);
        lcr_fmt = 4'b1100;
        push_byte(8'h03);
        ticks(35);
        chk("R5 not yet 5P2", timeout_pend, 0);
        ticks(1);
        chk("R5 expiry 5P2", timeout_pend, 1);
        lcr_fmt = 4'b0011;
    endtask

    task automatic t_flush();
        push_byte(8'h10);
        push_break();
        push_byte(8'hFF);
        push_byte(8'hFF);
        for (int k = 0; k < 13; k++) push_byte(8'(k));
        chk("R3 overrun before flush", lsr_oe, 1);
        wr_fcr(1'b1, 1'b1, 2'd0);
        chk("R8 count", rx_count, 0);
        chk("R8 dr", lsr_dr, 0);
        chk("R8 bi", lsr_bi, 0);
        chk("R8 oe kept", lsr_oe, 1);
        read_lsr();
        push_byte(8'h77);
        wr_fcr(1'b0, 1'b0, 2'd0);
        chk("R8 mode hold", fifo_en, 0);
        chk("R8 disable flush count", rx_count, 0);
        chk("R8 disable flush dr", lsr_dr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hold();
        t_fifo_order();
        t_trigger();
        t_overrun();
        t_break();
        t_timeout();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule